// File: doc/BRIEF.md
# Clock-Loss Watchdog with Sticky Failover

This block watches a primary oscillator clock from an independent backup clock. It generates the CPU clock from one of the two. While the oscillator keeps toggling, the CPU clock comes from the oscillator. When the backup domain sees no oscillator edge for a configurable number of its own cycles, the block does three things: it raises an interrupt request, sets a fail flag, and hands the CPU clock to the backup source through a glitch-free switch. The hand-over is permanent. Only an asynchronous hardware reset returns the CPU clock to the oscillator, even if the oscillator starts toggling again.

A static mode input sends the selected source either straight to the CPU clock or through a shared divide-by-two stage. A static enable input turns supervision off. With enable low, the backup path is held idle, no interrupt or fail flag can appear, and the oscillator keeps driving the CPU clock. Oscillator edges reach the backup domain as a toggle flip-flop followed by a synchronizer. The interrupt request is a level signal that software clears with an acknowledge. That acknowledge is sampled on the backup clock, and after a failure the backup clock is also the CPU clock.

Top module: `clk_loss_guard`

## Requirements
- R1: With sup_en high, once the oscillator stops, irq and fail_stat rise together no later than LOSS_CYCLES+3 rising edges of bak_clk after the last oscillator rising edge, and not before LOSS_CYCLES+1. While the oscillator toggles at least once every two backup cycles, neither output rises.
- R2: irq is a level. It stays high until irq_ack is sampled high on a bak_clk rising edge, and it is low from that edge on. irq is never high while fail_stat is low.
- R3: fail_stat stays high from the failure until rst_n is asserted. Neither irq_ack nor a restarted oscillator clears it.
- R4: After a failure with div_mode low, cpu_clk toggles with the bak_clk period. It stays on bak_clk even after the oscillator resumes.
- R5: With div_mode high, the cpu_clk period is twice the period of the selected source. This holds for the oscillator before a failure and for bak_clk after one.
- R6: With div_mode low and no failure, the cpu_clk period equals the oscillator period.
- R7: With sup_en low, irq and fail_stat stay low even when the oscillator stops, and cpu_clk produces no edges while the oscillator is stopped. cpu_clk follows the oscillator, directly or halved according to div_mode.
- R8: The switch from oscillator to backup is glitch-free. The two source enables are never active together, and no cpu_clk phase during a failover is shorter than half a bak_clk period.
- R9: While rst_n is low, irq and fail_stat are low. After release, cpu_clk is taken from the oscillator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Supervised primary oscillator clock |
| bak_clk | input | 1 | Independent backup clock that runs the supervision |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sup_en | input | 1 | Supervision enable, active high, static after reset |
| div_mode | input | 1 | 1: cpu_clk is the source divided by two; 0: undivided. Static after reset |
| irq_ack | input | 1 | Clears irq, sampled on bak_clk |
| irq | output | 1 | Clock-fail interrupt request level |
| fail_stat | output | 1 | Sticky clock-fail status |
| cpu_clk | output | 1 | CPU clock output |

## Verification
The hardest case to reach is the failover itself. The oscillator must stop at a known phase, so the test can check both the detection window and the shape of the first backup pulses. The bench therefore gates its oscillator generator right after a rising edge, leaving the oscillator stuck high. It then counts backup edges until irq appears, while an edge monitor records the shortest cpu_clk phase across the switch. A later restart of the oscillator probes stickiness, because the restart gives the design a real chance to switch back.

// File: rtl/clg_pkg.sv
package clg_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Which source currently drives the mux output: bit0 oscillator, bit1 backup
  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_OSC  = 2'b01,
    SRC_BAK  = 2'b10,
    SRC_BOTH = 2'b11
  } clk_src_e;

  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/clg_sync.sv
module clg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clg_edge_mon.sv
module clg_edge_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic osc_clk,
  input  logic bak_clk,
  input  logic rst_n,
  output logic edge_seen
);
  timeunit 1ns;
  timeprecision 1ps;

  logic osc_tgl;
  logic tgl_sync;
  logic tgl_prev;

  // one bit flips on every oscillator rising edge
  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) osc_tgl <= 1'b0;
    else        osc_tgl <= ~osc_tgl;
  end

  clg_sync #(.STAGES(SYNC_STAGES)) u_tgl_sync (
    .clk  (bak_clk),
    .rst_n(rst_n),
    .d    (osc_tgl),
    .q    (tgl_sync)
  );

  always_ff @(posedge bak_clk or negedge rst_n) begin
    if (!rst_n) tgl_prev <= 1'b0;
    else        tgl_prev <= tgl_sync;
  end

  assign edge_seen = tgl_sync ^ tgl_prev;
endmodule

// File: rtl/clg_loss_det.sv
module clg_loss_det
  import clg_pkg::*;
#(
  parameter int LOSS_CYCLES = 8
) (
  input  logic bak_clk,
  input  logic rst_n,
  input  logic edge_seen,
  input  logic irq_ack,
  output logic lost,
  output logic irq
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CW = cnt_width(LOSS_CYCLES);
  localparam logic [CW-1:0] QUIET_LAST = CW'(LOSS_CYCLES - 1);

  logic [CW-1:0] quiet_cnt;
  logic          declare;

  assign declare = !lost && !edge_seen && (quiet_cnt == QUIET_LAST);

  always_ff @(posedge bak_clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_cnt <= '0;
      lost      <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (edge_seen)
        quiet_cnt <= '0;
      else if (!lost && quiet_cnt != QUIET_LAST)
        quiet_cnt <= quiet_cnt + 1'b1;

      if (declare) begin
        lost <= 1'b1;
        irq  <= 1'b1;
      end else if (irq_ack) begin
        irq <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clg_clk_mux.sv
module clg_clk_mux
  import clg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     osc_clk,
  input  logic     bak_clk,
  input  logic     rst_n,
  input  logic     sel_bak,
  output logic     mux_clk,
  output clk_src_e active_src
);
  timeunit 1ns;
  timeprecision 1ps;

  logic osc_clr_n;
  logic osc_want;
  logic osc_want_s;
  logic osc_en;
  logic osc_en_s;
  logic bak_en;

  // a lost oscillator cannot clock its own disable, so selection clears it
  assign osc_clr_n = rst_n & ~sel_bak;
  assign osc_want  = ~sel_bak & ~bak_en;

  clg_sync #(.STAGES(SYNC_STAGES)) u_osc_side (
    .clk  (osc_clk),
    .rst_n(osc_clr_n),
    .d    (osc_want),
    .q    (osc_want_s)
  );

  always_ff @(negedge osc_clk or negedge osc_clr_n) begin
    if (!osc_clr_n) osc_en <= 1'b0;
    else            osc_en <= osc_want_s;
  end

  clg_sync #(.STAGES(SYNC_STAGES)) u_bak_side (
    .clk  (bak_clk),
    .rst_n(rst_n),
    .d    (osc_en),
    .q    (osc_en_s)
  );

  always_ff @(negedge bak_clk or negedge rst_n) begin
    if (!rst_n) bak_en <= 1'b0;
    else        bak_en <= sel_bak & ~osc_en_s;
  end

  assign mux_clk    = (osc_clk & osc_en) | (bak_clk & bak_en);
  assign active_src = clk_src_e'({bak_en, osc_en});
endmodule

// File: rtl/clg_prescale.sv
module clg_prescale (
  input  logic clk_in,
  input  logic rst_n,
  input  logic div_mode,
  output logic clk_out
);
  timeunit 1ns;
  timeprecision 1ps;

  logic half;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) half <= 1'b0;
    else        half <= ~half;
  end

  assign clk_out = div_mode ? half : clk_in;
endmodule

// File: rtl/clk_loss_guard.sv
module clk_loss_guard #(
  parameter int LOSS_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic osc_clk,
  input  logic bak_clk,
  input  logic rst_n,
  input  logic sup_en,
  input  logic div_mode,
  input  logic irq_ack,
  output logic irq,
  output logic fail_stat,
  output logic cpu_clk
);
  timeunit 1ns;
  timeprecision 1ps;

  logic sup_rst_n;
  logic edge_seen;
  logic lost;
  logic mux_clk;
  clg_pkg::clk_src_e active_src;

  // supervision held in reset while disabled: idle backup path, no request
  assign sup_rst_n = rst_n & sup_en;

  clg_edge_mon #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .osc_clk  (osc_clk),
    .bak_clk  (bak_clk),
    .rst_n    (sup_rst_n),
    .edge_seen(edge_seen)
  );

  clg_loss_det #(.LOSS_CYCLES(LOSS_CYCLES)) u_det (
    .bak_clk  (bak_clk),
    .rst_n    (sup_rst_n),
    .edge_seen(edge_seen),
    .irq_ack  (irq_ack),
    .lost     (lost),
    .irq      (irq)
  );

  clg_clk_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .osc_clk   (osc_clk),
    .bak_clk   (bak_clk),
    .rst_n     (rst_n),
    .sel_bak   (lost),
    .mux_clk   (mux_clk),
    .active_src(active_src)
  );

  clg_prescale u_div (
    .clk_in  (mux_clk),
    .rst_n   (rst_n),
    .div_mode(div_mode),
    .clk_out (cpu_clk)
  );

  assign fail_stat = lost;
endmodule

// File: rtl/clk_loss_guard_chk.sv
module clk_loss_guard_chk (
  input logic bak_clk,
  input logic rst_n,
  input logic sup_en,
  input logic irq_ack,
  input logic irq,
  input logic fail_stat
);
  timeunit 1ns;
  timeprecision 1ps;

  AST_IRQ_WITH_FAIL: assert property (@(posedge bak_clk) disable iff (!rst_n)
    $rose(irq) |-> $rose(fail_stat)); // R1
  AST_IRQ_NEEDS_FAIL: assert property (@(posedge bak_clk) disable iff (!rst_n)
    irq |-> fail_stat); // R2
  AST_IRQ_HOLD: assert property (@(posedge bak_clk) disable iff (!rst_n)
    irq && !irq_ack |=> irq); // R2
  AST_ACK_CLEARS: assert property (@(posedge bak_clk) disable iff (!rst_n)
    irq && irq_ack |=> !irq); // R2
  AST_FAIL_STICKY: assert property (@(posedge bak_clk) disable iff (!rst_n)
    fail_stat |=> fail_stat); // R3
  AST_DISABLED_QUIET: assert property (@(posedge bak_clk) disable iff (!rst_n)
    !sup_en |-> !irq && !fail_stat); // R7
endmodule

module clg_clk_mux_chk
  import clg_pkg::*;
(
  input logic     bak_clk,
  input logic     rst_n,
  input clk_src_e active_src
);
  timeunit 1ns;
  timeprecision 1ps;

  AST_ONE_SOURCE: assert property (@(posedge bak_clk) disable iff (!rst_n)
    $onehot0(active_src)); // R8
  AST_NO_RETURN: assert property (@(posedge bak_clk) disable iff (!rst_n)
    active_src == SRC_BAK |=> active_src == SRC_BAK); // R4
endmodule

bind clk_loss_guard clk_loss_guard_chk u_chk (
  .bak_clk  (bak_clk),
  .rst_n    (rst_n),
  .sup_en   (sup_en),
  .irq_ack  (irq_ack),
  .irq      (irq),
  .fail_stat(fail_stat)
);

bind clg_clk_mux clg_clk_mux_chk u_mux_chk (
  .bak_clk   (bak_clk),
  .rst_n     (rst_n),
  .active_src(active_src)
);

// File: tb/clk_loss_guard_tb.sv
module clk_loss_guard_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int  N       = 8;
  localparam real BAK_PER = 5.0;
  localparam real OSC_PER = 12.0;

  logic osc_clk = 1'b0;
  logic bak_clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_en = 1'b1;
  logic div_mode = 1'b0;
  logic irq_ack = 1'b0;
  logic irq, fail_stat, cpu_clk;
  bit   osc_run = 1'b1;

  int checks = 0;
  int errors = 0;
  int cpu_edges = 0;
  bit track_w = 1'b0;
  real min_w = 1000.0;
  real last_t = 0.0;

  clk_loss_guard #(.LOSS_CYCLES(N)) u_dut (
    .osc_clk(osc_clk), .bak_clk(bak_clk), .rst_n(rst_n), .sup_en(sup_en),
    .div_mode(div_mode), .irq_ack(irq_ack), .irq(irq),
    .fail_stat(fail_stat), .cpu_clk(cpu_clk)
  );

  always #2.5 bak_clk = ~bak_clk;
  initial forever begin
    #6;
    if (osc_run) osc_clk = ~osc_clk;
  end

  always @(posedge cpu_clk) cpu_edges <= cpu_edges + 1;
  always @(cpu_clk) begin
    if (track_w && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
    last_t = $realtime;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit en, input bit mode);
    rst_n = 1'b0;
    sup_en = en;
    div_mode = mode;
    irq_ack = 1'b0;
    osc_run = 1'b1;
    repeat (3) @(negedge bak_clk);
    chk(!irq && !fail_stat, "R9", "outputs in reset", real'(irq + fail_stat), 0.0);
    rst_n = 1'b1;
    repeat (12) @(negedge bak_clk);
  endtask

  task automatic meas(output real p);
    real t0;
    @(posedge cpu_clk);
    @(posedge cpu_clk);
    t0 = $realtime;
    @(posedge cpu_clk);
    p = $realtime - t0;
  endtask

  function automatic bit near(input real a, input real b);
    return (a - b < 0.3) && (b - a < 0.3);
  endfunction

  // stop the oscillator right after a rising edge; return bak edges to irq
  task automatic stop_osc_and_wait(output int cnt);
    @(posedge osc_clk);
    osc_run = 1'b0;
    cnt = 0;
    while (!irq && cnt < 40) begin
      @(posedge bak_clk);
      #1;
      cnt++;
    end
  endtask

  task automatic t_reset_direct();
    real p;
    do_reset(1'b1, 1'b0);
    chk(!irq && !fail_stat, "R9", "outputs after release", real'(irq + fail_stat), 0.0);
    meas(p);
    chk(near(p, OSC_PER), "R6", "direct oscillator period", p, OSC_PER);
    chk(near(p, OSC_PER), "R9", "source after reset", p, OSC_PER);
    repeat (60) @(negedge bak_clk);
    chk(!irq && !fail_stat, "R1", "no detection while running", real'(irq + fail_stat), 0.0);
  endtask

  task automatic t_failover_direct();
    int cnt;
    real p;
    do_reset(1'b1, 1'b0);
    min_w = 1000.0;
    track_w = 1'b1;
    stop_osc_and_wait(cnt);
    chk(cnt >= N + 1 && cnt <= N + 3, "R1", "bak edges to irq", real'(cnt), real'(N + 3));
    chk(fail_stat == 1'b1, "R1", "fail_stat with irq", real'(fail_stat), 1.0);
    repeat (12) @(negedge bak_clk);
    track_w = 1'b0;
    chk(min_w > BAK_PER / 2.0 - 0.2, "R8", "shortest phase at switch", min_w, BAK_PER / 2.0);
    meas(p);
    chk(near(p, BAK_PER), "R4", "period after failover", p, BAK_PER);
    osc_run = 1'b1;
    repeat (30) @(negedge bak_clk);
    meas(p);
    chk(near(p, BAK_PER), "R4", "period after oscillator restart", p, BAK_PER);
    @(negedge bak_clk);
    chk(irq == 1'b1, "R2", "irq held without ack", real'(irq), 1.0);
    chk(fail_stat == 1'b1, "R3", "fail after restart", real'(fail_stat), 1.0);
    irq_ack = 1'b1;
    @(negedge bak_clk);
    irq_ack = 1'b0;
    chk(irq == 1'b0, "R2", "irq after ack", real'(irq), 0.0);
    chk(fail_stat == 1'b1, "R3", "fail after ack", real'(fail_stat), 1.0);
    repeat (20) @(negedge bak_clk);
    chk(irq == 1'b0, "R2", "irq stays cleared", real'(irq), 0.0);
  endtask

  task automatic t_failover_divided();
    int cnt;
    real p;
    do_reset(1'b1, 1'b1);
    meas(p);
    chk(near(p, 2.0 * OSC_PER), "R5", "divided oscillator period", p, 2.0 * OSC_PER);
    stop_osc_and_wait(cnt);
    chk(irq == 1'b1, "R1", "irq in divided mode", real'(irq), 1.0);
    repeat (12) @(negedge bak_clk);
    meas(p);
    chk(near(p, 2.0 * BAK_PER), "R5", "divided backup period", p, 2.0 * BAK_PER);
  endtask

  task automatic t_disabled();
    int e0;
    real p;
    do_reset(1'b0, 1'b0);
    meas(p);
    chk(near(p, OSC_PER), "R7", "disabled direct period", p, OSC_PER);
    @(posedge osc_clk);
    osc_run = 1'b0;
    repeat (4 * N) @(negedge bak_clk);
    chk(!irq && !fail_stat, "R7", "no request when disabled", real'(irq + fail_stat), 0.0);
    e0 = cpu_edges;
    repeat (20) @(negedge bak_clk);
    chk(cpu_edges == e0, "R7", "no cpu edges with oscillator stopped", real'(cpu_edges - e0), 0.0);
    do_reset(1'b0, 1'b1);
    meas(p);
    chk(near(p, 2.0 * OSC_PER), "R7", "disabled divided period", p, 2.0 * OSC_PER);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_direct();
    t_failover_direct();
    t_failover_divided();
    t_disabled();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule